// File: doc/BRIEF.md
# Banked General-Purpose Pin Controller

This block is a memory-mapped controller for a set of general-purpose pins, split into sections of eight pins each. Every section owns its own register bank at a fixed address stride. The bank holds the pin direction, the driven output value, a view of the synchronized input level, and per-pin interrupt state. That state is a raw status bit, a mask bit and a selector between level and rising-edge detection. The pad ring receives an output value and an output enable for every pin. It returns the pin level, which enters the block through a two-flop synchronizer.

Software reaches the registers over a simple synchronous bus. A request is held for one clock: select, write flag, byte address and write data. Read data comes back registered on the next cycle. Mask bits are set and cleared through two separate addresses, so no read-modify-write sequence is needed. Status bits are cleared by writing ones. A single registered interrupt line is high whenever any section has a status bit set that is not masked.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: The address selects the section with bits [7:6] (section s covers byte addresses s*0x40 to s*0x40+0x3F). Bits [5:0] select the register within the section. Pin n maps to section n/8 and to bit n%8 of every register in that section, carried on data bits [7:0].
- R2: Register +0x10 holds the direction (1 = input, 0 = output) and reads back. The output enable of each pin equals the inverse of its direction bit, starting from the cycle after the write.
- R3: Register +0x14 holds the output data and reads back. It drives the output pins from the cycle after the write, and the output pins change only on a bus write.
- R4: Register +0x18 returns the pin levels after a two-flop synchronizer, and writes to it are ignored.
- R5: For a pin with interrupt type 0 (edge), a rising edge of the synchronized input sets its raw status bit. With the pin unmasked, the interrupt output rises on the fourth clock edge after the pin change.
- R6: For a pin with interrupt type 1 (level, set through register +0x20, which reads back), the status bit is set while the synchronized input is high. A clear while the level is still high leaves the bit set.
- R7: Writing ones to register +0x04 clears those raw status bits, and +0x04 reads the raw status. An edge-type pin held high stays cleared.
- R8: Writing ones to +0x08 sets mask bits, and writing ones to +0x0C clears them. +0x08 reads the mask, and +0x0C reads 0.
- R9: Register +0x00 reads raw status AND NOT mask and is read-only.
- R10: The interrupt output is the registered OR of all masked-status bits over every section.
- R11: Reset clears direction, output data, status and interrupt type, sets every mask bit, and leaves the interrupt output low.
- R12: Unused offsets read 0 and ignore writes.
- R13: Read data appears on the cycle after the read request. Read data bits [31:8] are zero, and read data is zero on any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data (bits [7:0] used) |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels from the pad ring |
| pin_out | output | 32 | Output values to the pad ring |
| pin_oe | output | 32 | Output enables to the pad ring |
| irq | output | 1 | Combined interrupt |

## Verification
Register effects have fixed latencies. Bus writes reach the pins one edge after the write is captured. Read data is sampled at the falling edge that follows the rising edge capturing the read. A pin change reaches the input register after two edges and the raw status after three. It reaches the interrupt output after four, so the bench checks the interrupt low after exactly three edges and high after the fourth. Status and mask checks are read back only after the synchronizer and detection stages have settled.

// File: rtl/gpio_sect_pkg.sv
package gpio_sect_pkg;
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_MSTAT   = 6'h00;
    localparam logic [OFF_W-1:0] OFF_RSTAT   = 6'h04;
    localparam logic [OFF_W-1:0] OFF_MSET    = 6'h08;
    localparam logic [OFF_W-1:0] OFF_MCLR    = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_DIR     = 6'h10;
    localparam logic [OFF_W-1:0] OFF_DOUT    = 6'h14;
    localparam logic [OFF_W-1:0] OFF_DIN     = 6'h18;
    localparam logic [OFF_W-1:0] OFF_ITYPE   = 6'h20;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_in;
        s_d.stab = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stab;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_sect_pkg::*;
#(
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [SECT_W-1:0] wdata,
    input  logic [SECT_W-1:0] pin_sync,
    output logic [SECT_W-1:0] dout,
    output logic [SECT_W-1:0] oe,
    output logic [SECT_W-1:0] mstat,
    output logic [SECT_W-1:0] rd_val
);
    typedef struct packed {
        logic [SECT_W-1:0] dir;
        logic [SECT_W-1:0] dout;
        logic [SECT_W-1:0] stat;
        logic [SECT_W-1:0] mask;
        logic [SECT_W-1:0] itype;
        logic [SECT_W-1:0] prev;
    } bank_t;

    bank_t b_d, b_q;
    logic [SECT_W-1:0] set_v;
    logic [SECT_W-1:0] clr_v;

    always_comb begin
        b_d   = b_q;
        clr_v = '0;
        // level pins follow the input, edge pins see rising transitions
        set_v = (b_q.itype & pin_sync) | (~b_q.itype & pin_sync & ~b_q.prev);
        b_d.prev = pin_sync;
        if (wr_en) begin
            unique case (off)
                OFF_RSTAT: clr_v      = wdata;
                OFF_MSET:  b_d.mask   = b_q.mask | wdata;
                OFF_MCLR:  b_d.mask   = b_q.mask & ~wdata;
                OFF_DIR:   b_d.dir    = wdata;
                OFF_DOUT:  b_d.dout   = wdata;
                OFF_ITYPE: b_d.itype  = wdata;
                default: ;
            endcase
        end
        b_d.stat = (b_q.stat & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q      <= '0;
            b_q.mask <= '1;
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        unique case (off)
            OFF_MSTAT: rd_val = b_q.stat & ~b_q.mask;
            OFF_RSTAT: rd_val = b_q.stat;
            OFF_MSET:  rd_val = b_q.mask;
            OFF_DIR:   rd_val = b_q.dir;
            OFF_DOUT:  rd_val = b_q.dout;
            OFF_DIN:   rd_val = pin_sync;
            OFF_ITYPE: rd_val = b_q.itype;
            default:   rd_val = '0;
        endcase
    end

    assign dout  = b_q.dout;
    assign oe    = ~b_q.dir;
    assign mstat = b_q.stat & ~b_q.mask;
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
    import gpio_sect_pkg::*;
#(
    parameter int NUM_SECT = 4,
    parameter int SECT_W   = 8,
    parameter int DATA_W   = 32,
    localparam int SIDX_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
    localparam int ADDR_W  = SIDX_W + OFF_W,
    localparam int PINS    = NUM_SECT * SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq;
    } top_t;

    top_t t_d, t_q;

    logic [PINS-1:0]   pin_sync;
    logic [PINS-1:0]   mstat_all;
    logic [SECT_W-1:0] rd_vals [NUM_SECT];
    logic [SIDX_W-1:0] sect_idx;
    logic [OFF_W-1:0]  off;

    assign sect_idx = bus_addr[ADDR_W-1:OFF_W];
    assign off      = bus_addr[OFF_W-1:0];

    gpio_sync2 #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_bank
        logic wr_hit;
        assign wr_hit = bus_sel && bus_wr && (sect_idx == SIDX_W'(s));

        gpio_bank #(.SECT_W(SECT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit),
            .off      (off),
            .wdata    (bus_wdata[SECT_W-1:0]),
            .pin_sync (pin_sync[s*SECT_W +: SECT_W]),
            .dout     (pin_out[s*SECT_W +: SECT_W]),
            .oe       (pin_oe[s*SECT_W +: SECT_W]),
            .mstat    (mstat_all[s*SECT_W +: SECT_W]),
            .rd_val   (rd_vals[s])
        );
    end

    always_comb begin
        t_d       = t_q;
        t_d.irq   = |mstat_all;
        t_d.rdata = '0;
        if (bus_sel && !bus_wr)
            t_d.rdata = DATA_W'(rd_vals[sect_idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata = t_q.rdata;
    assign irq       = t_q.irq;
endmodule

// File: rtl/gpio_sect_ctrl_chk.sv
module gpio_sect_ctrl_chk #(
    parameter int NUM_SECT = 4,
    parameter int SECT_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int PINS     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);
    // R2: output enable takes the inverse of the written direction
    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[5:0] == 6'h10) |=>
        (pin_oe[$past(bus_addr[ADDR_W-1:6]) * SECT_W +: SECT_W] == ~$past(bus_wdata[SECT_W-1:0])));

    // R3: output pins take the written data
    p_out_follows_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[5:0] == 6'h14) |=>
        (pin_out[$past(bus_addr[ADDR_W-1:6]) * SECT_W +: SECT_W] == $past(bus_wdata[SECT_W-1:0])));

    // R3: no bus write, no change at the pad side
    p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R13: read data is zero after any cycle without a read
    p_rdata_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));

    // R13: upper read data bits stay zero
    p_rdata_upper_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> (bus_rdata[DATA_W-1:SECT_W] == '0));
endmodule

bind gpio_sect_ctrl gpio_sect_ctrl_chk #(
    .NUM_SECT (NUM_SECT),
    .SECT_W   (SECT_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .PINS     (PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_sect_ctrl_tb.sv
module gpio_sect_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_sect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h10, 8'h00, 8'd11},  // R11 direction resets to 0
        '{1'b0, 8'hC8, 8'hFF, 8'd11},  // R11 mask resets to all ones
        '{1'b0, 8'h60, 8'h00, 8'd11},  // R11 interrupt type resets to 0
        '{1'b1, 8'h50, 8'hA5, 8'd2},   // R2 section 1 direction
        '{1'b0, 8'h50, 8'hA5, 8'd2},   // R2 readback
        '{1'b0, 8'h10, 8'h00, 8'd1},   // R1 section 0 untouched
        '{1'b1, 8'h94, 8'h3C, 8'd3},   // R3 section 2 output data
        '{1'b0, 8'h94, 8'h3C, 8'd3},   // R3 readback
        '{1'b1, 8'hCC, 8'h0F, 8'd8},   // R8 clear mask bits
        '{1'b0, 8'hC8, 8'hF0, 8'd8},   // R8 mask reads back
        '{1'b0, 8'hCC, 8'h00, 8'd8},   // R8 clear address reads 0
        '{1'b1, 8'hE0, 8'h55, 8'd6},   // R6 interrupt type
        '{1'b0, 8'hE0, 8'h55, 8'd6},   // R6 readback
        '{1'b1, 8'h3C, 8'h77, 8'd12},  // R12 unused offset write
        '{1'b0, 8'h3C, 8'h00, 8'd12},  // R12 reads 0
        '{1'b1, 8'h18, 8'hFF, 8'd4},   // R4 input register write ignored
        '{1'b0, 8'h18, 8'h00, 8'd4}    // R4 still reflects the pins
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {24'h0, d};
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        wait_edges(3);
        // R11 reset state at the pins
        check("R11 irq", {31'h0, irq}, 32'h0);
        check("R11 oe", pin_oe, 32'hFFFF_FFFF);
        check("R11 out", pin_out, 32'h0);
        rst_n = 1'b1;
        wait_edges(1);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].wr) bus_write(VEC[v].addr, VEC[v].data);
            else begin
                bus_read(VEC[v].addr, rd);
                check($sformatf("R%0d vec %0d", VEC[v].req, v), rd, {24'h0, VEC[v].data});
            end
        end

        // R2 / R3 pad side after the table
        check("R2 oe map", pin_oe, 32'hFFFF_5AFF);
        check("R3 out map", pin_out, 32'h003C_0000);

        // R13 idle cycle gives zero read data
        wait_edges(1);
        check("R13 idle rdata", bus_rdata, 32'h0);

        // R4 input register after synchronizer
        pin_in[15:8] = 8'h81;
        wait_edges(3);
        bus_read(8'h58, rd);
        check("R4 input", rd, 32'h81);

        // R5 edge interrupt on section 0 pin 2, exact latency
        bus_write(8'h0C, 8'h04);
        pin_in[2] = 1'b1;
        wait_edges(3);
        check("R5 irq not yet", {31'h0, irq}, 32'h0);
        wait_edges(1);
        check("R5 irq raised", {31'h0, irq}, 32'h1);
        bus_read(8'h04, rd);
        check("R5 raw status", rd, 32'h04);
        bus_read(8'h00, rd);
        check("R9 masked status", rd, 32'h04);
        bus_write(8'h00, 8'hFF);
        bus_read(8'h00, rd);
        check("R9 read-only", rd, 32'h04);

        // R7 clear while pin is still high, edge pin stays clear
        bus_write(8'h04, 8'h04);
        wait_edges(2);
        bus_read(8'h04, rd);
        check("R7 cleared", rd, 32'h0);
        check("R10 irq low", {31'h0, irq}, 32'h0);

        // R6 level interrupt on section 3 pin 0
        pin_in[24] = 1'b1;
        wait_edges(4);
        bus_read(8'hC4, rd);
        check("R6 level set", rd, 32'h01);
        check("R10 irq from section 3", {31'h0, irq}, 32'h1);
        bus_write(8'hC4, 8'h01);
        bus_read(8'hC4, rd);
        check("R6 re-set while high", rd, 32'h01);

        // R8 / R9 / R10 masking the set bit
        bus_write(8'hC8, 8'h01);
        bus_read(8'hC0, rd);
        check("R9 masked out", rd, 32'h0);
        wait_edges(1);
        check("R10 irq masked", {31'h0, irq}, 32'h0);

        // R6 drop level then clear
        pin_in[24] = 1'b0;
        wait_edges(3);
        bus_write(8'hC4, 8'h01);
        bus_read(8'hC4, rd);
        check("R6 cleared after drop", rd, 32'h0);

        // R1 section 1 edge status, masked, no irq
        bus_read(8'h44, rd);
        check("R1 section 1 status", rd, 32'h81);
        check("R10 masked section silent", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule